// File: doc/BRIEF.md
# Two-Port Semaphore Flag Bank

This block holds a small bank of hardware ownership tokens that two independent ports share. Software on each side uses the tokens to agree which side may touch a shared memory region. A port claims a token by writing a 0 to it and gives it back by writing a 1. Reading a token reports whether the reading port currently holds it. The answer is copied onto every bit of the read bus.

A claim that cannot be granted at once, because the other port holds the token, is remembered as pending. It is granted automatically on the clock edge at which the holder gives the token back. When both ports claim a free token in the same cycle, the left port wins and the right port's claim stays pending. A port that drives token select and chip enable together has made an illegal access. That access changes no token, and the port's error output pulses in the following cycle. All state is updated on the rising clock edge and cleared by a synchronous, active-high reset. Read data is combinational from the token state, so it reflects all writes committed at earlier edges.

Top module: `sem_flag_bank`

## Requirements
- R1: After reset every token is free, every read of any token by either port returns 9'h1FF, and both error outputs are 0.
- R2: A port makes a token access only when sel=1 and ce=0. With we=1 the access is a write. With we=0 and oe=1 it is a read. Otherwise dout is 9'h000, and a write with ce=1 and sel=0 leaves every token unchanged.
- R3: The 3-bit address selects one of eight tokens, and an access never changes a token at another address.
- R4: A write takes its value from din0 alone: 0 is a claim and 1 is a give-back.
- R5: A read returns 9'h000 when the reading port holds the token and 9'h1FF otherwise. Every bit carries the same value.
- R6: A claim on a free token is granted at the next clock edge. A claim on a token the other port holds becomes pending and grants nothing.
- R7: A pending claim is granted at the same edge at which the holder gives the token back.
- R8: A give-back by a port that does not hold the token leaves the holder unchanged and cancels that port's own pending claim.
- R9: When both ports claim the same free token in one cycle, the left port is granted and the right port's claim stays pending.
- R10: sel=1 together with ce=1 changes no token, and it sets that port's err output to 1 for exactly the following cycle.
- R11: A token is never held by both ports at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| l_sel | input | 1 | Left token select |
| l_ce | input | 1 | Left chip enable (memory side) |
| l_we | input | 1 | Left write (1) / read (0) |
| l_oe | input | 1 | Left output enable |
| l_addr | input | 3 | Left token address |
| l_din0 | input | 1 | Left write value |
| l_dout | output | 9 | Left read data |
| l_err | output | 1 | Left illegal-access pulse |
| r_sel | input | 1 | Right token select |
| r_ce | input | 1 | Right chip enable (memory side) |
| r_we | input | 1 | Right write (1) / read (0) |
| r_oe | input | 1 | Right output enable |
| r_addr | input | 3 | Right token address |
| r_din0 | input | 1 | Right write value |
| r_dout | output | 9 | Right read data |
| r_err | output | 1 | Right illegal-access pulse |

## Verification
Two situations can put both ports on one token in the same cycle. In the first, both ports claim a free token at once. In the second, one port gives a token back while the other port claims it or already has a claim pending. The bench provokes each case by driving both ports in a single vector. In the next cycle it reads the token from both sides and checks that exactly the expected side sees 9'h000, with left priority on a tie and an immediate hand-over on a give-back. A cancelled claim is also judged this way: after the holder gives the token back, both sides must read 9'h1FF.

// File: rtl/sem_pkg.sv
package sem_pkg;
  // Holder of one token
  typedef enum logic [1:0] {
    HOLD_NONE  = 2'd0,
    HOLD_LEFT  = 2'd1,
    HOLD_RIGHT = 2'd2
  } holder_e;

  // Access kind decoded from one port's control pins
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_BAD   = 2'd3
  } access_e;
endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode
  import sem_pkg::*;
#(
  parameter int NUM_FLAGS = 8,
  parameter int ADDR_W    = 3
) (
  input  logic                 sel,
  input  logic                 ce,
  input  logic                 we,
  input  logic                 oe,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 din0,
  output logic [NUM_FLAGS-1:0] claim_vec,
  output logic [NUM_FLAGS-1:0] give_vec,
  output logic                 rd_en,
  output logic                 bad
);
  access_e kind;

  always_comb begin
    kind = ACC_IDLE;
    if (sel && ce)             kind = ACC_BAD;
    else if (sel && we)        kind = ACC_WRITE;
    else if (sel && oe)        kind = ACC_READ;
  end

  assign rd_en = (kind == ACC_READ);
  assign bad   = (kind == ACC_BAD);

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_hit
    logic hit;
    assign hit          = (kind == ACC_WRITE) && (addr == ADDR_W'(i));
    assign claim_vec[i] = hit && !din0;
    assign give_vec[i]  = hit &&  din0;
  end
endmodule

// File: rtl/sem_flag_cell.sv
module sem_flag_cell
  import sem_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic claim_l,
  input  logic give_l,
  input  logic claim_r,
  input  logic give_r,
  output logic held_l,
  output logic held_r
);
  holder_e holder_q, holder_d;
  logic    wait_l_q, wait_l_d;
  logic    wait_r_q, wait_r_d;

  always_comb begin
    holder_d = holder_q;
    wait_l_d = wait_l_q;
    wait_r_d = wait_r_q;
    // give-backs first; they also cancel the port's own pending claim
    if (give_l) begin
      wait_l_d = 1'b0;
      if (holder_q == HOLD_LEFT) holder_d = HOLD_NONE;
    end
    if (give_r) begin
      wait_r_d = 1'b0;
      if (holder_q == HOLD_RIGHT) holder_d = HOLD_NONE;
    end
    // new claims join the pending set
    if (claim_l && holder_q != HOLD_LEFT)  wait_l_d = 1'b1;
    if (claim_r && holder_q != HOLD_RIGHT) wait_r_d = 1'b1;
    // grant a free token, left first
    if (holder_d == HOLD_NONE) begin
      if (wait_l_d) begin
        holder_d = HOLD_LEFT;
        wait_l_d = 1'b0;
      end else if (wait_r_d) begin
        holder_d = HOLD_RIGHT;
        wait_r_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      holder_q <= HOLD_NONE;
      wait_l_q <= 1'b0;
      wait_r_q <= 1'b0;
    end else begin
      holder_q <= holder_d;
      wait_l_q <= wait_l_d;
      wait_r_q <= wait_r_d;
    end
  end

  assign held_l = (holder_q == HOLD_LEFT);
  assign held_r = (holder_q == HOLD_RIGHT);
endmodule

// File: rtl/sem_read_mux.sv
module sem_read_mux #(
  parameter int NUM_FLAGS = 8,
  parameter int ADDR_W    = 3,
  parameter int DATA_W    = 9
) (
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [NUM_FLAGS-1:0] held_vec,
  output logic [DATA_W-1:0]    dout
);
  logic mine;

  always_comb begin
    mine = 1'b0;
    for (int i = 0; i < NUM_FLAGS; i++)
      if (addr == ADDR_W'(i)) mine = held_vec[i];
  end

  assign dout = rd_en ? {DATA_W{~mine}} : '0;
endmodule

// File: rtl/sem_flag_bank.sv
module sem_flag_bank #(
  parameter int NUM_FLAGS = 8,
  parameter int DATA_W    = 9,
  localparam int ADDR_W   = (NUM_FLAGS > 1) ? $clog2(NUM_FLAGS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l_sel,
  input  logic              l_ce,
  input  logic              l_we,
  input  logic              l_oe,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_din0,
  output logic [DATA_W-1:0] l_dout,
  output logic              l_err,
  input  logic              r_sel,
  input  logic              r_ce,
  input  logic              r_we,
  input  logic              r_oe,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_din0,
  output logic [DATA_W-1:0] r_dout,
  output logic              r_err
);
  logic [NUM_FLAGS-1:0] claim_l, give_l, claim_r, give_r;
  logic [NUM_FLAGS-1:0] held_l_vec, held_r_vec;
  logic                 rd_l, rd_r, bad_l, bad_r;

  sem_port_decode #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W)) dec_l_i (
    .sel(l_sel), .ce(l_ce), .we(l_we), .oe(l_oe), .addr(l_addr), .din0(l_din0),
    .claim_vec(claim_l), .give_vec(give_l), .rd_en(rd_l), .bad(bad_l)
  );

  sem_port_decode #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W)) dec_r_i (
    .sel(r_sel), .ce(r_ce), .we(r_we), .oe(r_oe), .addr(r_addr), .din0(r_din0),
    .claim_vec(claim_r), .give_vec(give_r), .rd_en(rd_r), .bad(bad_r)
  );

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    sem_flag_cell cell_i (
      .clk(clk), .rst(rst),
      .claim_l(claim_l[i]), .give_l(give_l[i]),
      .claim_r(claim_r[i]), .give_r(give_r[i]),
      .held_l(held_l_vec[i]), .held_r(held_r_vec[i])
    );
  end

  sem_read_mux #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) mux_l_i (
    .rd_en(rd_l), .addr(l_addr), .held_vec(held_l_vec), .dout(l_dout)
  );

  sem_read_mux #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) mux_r_i (
    .rd_en(rd_r), .addr(r_addr), .held_vec(held_r_vec), .dout(r_dout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      l_err <= 1'b0;
      r_err <= 1'b0;
    end else begin
      l_err <= bad_l;
      r_err <= bad_r;
    end
  end
endmodule

// File: rtl/sem_flag_bank_chk.sv
module sem_flag_bank_chk #(
  parameter int NUM_FLAGS = 8,
  parameter int DATA_W    = 9,
  parameter int ADDR_W    = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 l_sel, l_ce, l_we, l_oe, l_din0,
  input logic [ADDR_W-1:0]    l_addr,
  input logic [DATA_W-1:0]    l_dout,
  input logic                 l_err,
  input logic                 r_sel, r_ce, r_we, r_oe, r_din0,
  input logic [ADDR_W-1:0]    r_addr,
  input logic [DATA_W-1:0]    r_dout,
  input logic                 r_err,
  input logic [NUM_FLAGS-1:0] held_l_vec,
  input logic [NUM_FLAGS-1:0] held_r_vec
);
  logic tie_claim;
  assign tie_claim = l_sel && !l_ce && l_we && !l_din0 &&
                     r_sel && !r_ce && r_we && !r_din0 && (l_addr == r_addr) &&
                     !held_l_vec[l_addr] && !held_r_vec[l_addr];

  AST_EXCLUSIVE_HOLDER: assert property (@(posedge clk) disable iff (rst)
    (held_l_vec & held_r_vec) == '0); // R11

  AST_ERR_AFTER_BAD_L: assert property (@(posedge clk) disable iff (rst)
    (l_sel && l_ce) |=> l_err); // R10

  AST_ERR_AFTER_BAD_R: assert property (@(posedge clk) disable iff (rst)
    (r_sel && r_ce) |=> r_err); // R10

  AST_ERR_ONLY_AFTER_BAD: assert property (@(posedge clk) disable iff (rst)
    (!(l_sel && l_ce)) |=> !l_err); // R10

  AST_BAD_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
    (l_sel && l_ce && !r_sel) |=> ($stable(held_l_vec) && $stable(held_r_vec))); // R10

  AST_READ_REPLICATED: assert property (@(posedge clk) disable iff (rst)
    (l_dout == '0) || (l_dout == '1)); // R5

  AST_IDLE_DOUT_ZERO: assert property (@(posedge clk) disable iff (rst)
    !(r_sel && !r_ce && !r_we && r_oe) |-> (r_dout == '0)); // R2

  AST_TIE_LEFT_WINS: assert property (@(posedge clk) disable iff (rst)
    tie_claim |=> held_l_vec[$past(l_addr)]); // R9
endmodule

bind sem_flag_bank sem_flag_bank_chk #(
  .NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rst(rst),
  .l_sel(l_sel), .l_ce(l_ce), .l_we(l_we), .l_oe(l_oe), .l_din0(l_din0),
  .l_addr(l_addr), .l_dout(l_dout), .l_err(l_err),
  .r_sel(r_sel), .r_ce(r_ce), .r_we(r_we), .r_oe(r_oe), .r_din0(r_din0),
  .r_addr(r_addr), .r_dout(r_dout), .r_err(r_err),
  .held_l_vec(held_l_vec), .held_r_vec(held_r_vec)
);

// File: tb/sem_flag_bank_tb.sv
module sem_flag_bank_tb_top;
  localparam int CLK_P = 10;
  localparam logic [1:0] OP_IDLE = 2'd0, OP_RD = 2'd1, OP_WR = 2'd2, OP_BAD = 2'd3;

  logic       clk = 1'b0, rst = 1'b1;
  logic       l_sel = 0, l_ce = 0, l_we = 0, l_oe = 0, l_din0 = 0;
  logic       r_sel = 0, r_ce = 0, r_we = 0, r_oe = 0, r_din0 = 0;
  logic [2:0] l_addr = 0, r_addr = 0;
  logic [8:0] l_dout, r_dout;
  logic       l_err, r_err;
  int         n_chk = 0, n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  sem_flag_bank dut_i (
    .clk(clk), .rst(rst),
    .l_sel(l_sel), .l_ce(l_ce), .l_we(l_we), .l_oe(l_oe), .l_addr(l_addr),
    .l_din0(l_din0), .l_dout(l_dout), .l_err(l_err),
    .r_sel(r_sel), .r_ce(r_ce), .r_we(r_we), .r_oe(r_oe), .r_addr(r_addr),
    .r_din0(r_din0), .r_dout(r_dout), .r_err(r_err)
  );

  // {op_l, addr_l, d_l, op_r, addr_r, d_r, exp_l, exp_r}; exp bit is replicated on reads
  localparam int NV = 28;
  localparam logic [13:0] VEC [NV] = '{
    {OP_RD,3'd0,1'b0, OP_RD,3'd0,1'b0, 1'b1,1'b1}, // 0  R1 free
    {OP_WR,3'd0,1'b0, OP_IDLE,3'd0,1'b0, 1'b0,1'b0}, // 1  R4 R6 claim
    {OP_RD,3'd0,1'b0, OP_RD,3'd0,1'b0, 1'b0,1'b1}, // 2  R5 R11
    {OP_RD,3'd3,1'b0, OP_WR,3'd0,1'b0, 1'b1,1'b0}, // 3  R3 R6 pending
    {OP_RD,3'd0,1'b0, OP_RD,3'd0,1'b0, 1'b0,1'b1}, // 4  R6 not granted
    {OP_WR,3'd0,1'b1, OP_RD,3'd0,1'b0, 1'b0,1'b1}, // 5  R7 give-back
    {OP_RD,3'd0,1'b0, OP_RD,3'd0,1'b0, 1'b1,1'b0}, // 6  R7 handed over
    {OP_WR,3'd0,1'b0, OP_WR,3'd0,1'b1, 1'b0,1'b0}, // 7  R7 claim + give same cycle
    {OP_RD,3'd0,1'b0, OP_RD,3'd0,1'b0, 1'b0,1'b1}, // 8  R7
    {OP_WR,3'd0,1'b1, OP_IDLE,3'd0,1'b0, 1'b0,1'b0}, // 9
    {OP_WR,3'd5,1'b0, OP_WR,3'd5,1'b0, 1'b0,1'b0}, // 10 R9 tie
    {OP_RD,3'd5,1'b0, OP_RD,3'd5,1'b0, 1'b0,1'b1}, // 11 R9 left wins
    {OP_WR,3'd5,1'b1, OP_IDLE,3'd0,1'b0, 1'b0,1'b0}, // 12 R9 right pending
    {OP_RD,3'd5,1'b0, OP_RD,3'd5,1'b0, 1'b1,1'b0}, // 13 R9 right granted
    {OP_WR,3'd2,1'b0, OP_WR,3'd5,1'b1, 1'b0,1'b0}, // 14
    {OP_RD,3'd2,1'b0, OP_RD,3'd5,1'b0, 1'b0,1'b1}, // 15 R3
    {OP_IDLE,3'd0,1'b0, OP_WR,3'd2,1'b0, 1'b0,1'b0}, // 16 R8 pending
    {OP_IDLE,3'd0,1'b0, OP_WR,3'd2,1'b1, 1'b0,1'b0}, // 17 R8 cancel
    {OP_RD,3'd2,1'b0, OP_RD,3'd2,1'b0, 1'b0,1'b1}, // 18 R8 holder kept
    {OP_WR,3'd2,1'b1, OP_IDLE,3'd0,1'b0, 1'b0,1'b0}, // 19
    {OP_RD,3'd2,1'b0, OP_RD,3'd2,1'b0, 1'b1,1'b1}, // 20 R8 no grant
    {OP_WR,3'd7,1'b0, OP_WR,3'd7,1'b1, 1'b0,1'b0}, // 21 R8 stray give
    {OP_RD,3'd7,1'b0, OP_RD,3'd7,1'b0, 1'b0,1'b1}, // 22 R8
    {OP_BAD,3'd7,1'b1, OP_IDLE,3'd0,1'b0, 1'b0,1'b0}, // 23 R10
    {OP_RD,3'd7,1'b0, OP_RD,3'd4,1'b0, 1'b0,1'b1}, // 24 R10 unchanged, R3
    {OP_WR,3'd7,1'b1, OP_WR,3'd6,1'b0, 1'b0,1'b0}, // 25
    {OP_RD,3'd6,1'b0, OP_BAD,3'd6,1'b1, 1'b1,1'b0}, // 26 R10
    {OP_RD,3'd7,1'b0, OP_RD,3'd6,1'b0, 1'b1,1'b0}  // 27 R10 unchanged
  };

  task automatic drive_l(input logic [1:0] op, input logic [2:0] a, input logic d);
    l_sel = (op != OP_IDLE); l_ce = (op == OP_BAD);
    l_we = (op == OP_WR) || (op == OP_BAD); l_oe = (op == OP_RD);
    l_addr = a; l_din0 = d;
  endtask

  task automatic drive_r(input logic [1:0] op, input logic [2:0] a, input logic d);
    r_sel = (op != OP_IDLE); r_ce = (op == OP_BAD);
    r_we = (op == OP_WR) || (op == OP_BAD); r_oe = (op == OP_RD);
    r_addr = a; r_din0 = d;
  endtask

  task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    #(CLK_P * 20000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: every token free from both sides, no error
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      drive_l(OP_RD, 3'(i), 1'b0); drive_r(OP_RD, 3'(7 - i), 1'b0);
      #1;
      check("R1 left reset read", l_dout, 9'h1FF);
      check("R1 right reset read", r_dout, 9'h1FF);
    end
    check("R1 err after reset", {7'd0, l_err, r_err}, 9'h000);

    // vector table
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      drive_l(VEC[v][13:12], VEC[v][11:9], VEC[v][8]);
      drive_r(VEC[v][7:6], VEC[v][5:3], VEC[v][2]);
      #1;
      check($sformatf("R5 vec %0d left", v), l_dout,
            (VEC[v][13:12] == OP_RD) ? {9{VEC[v][1]}} : 9'h000);
      check($sformatf("R5 vec %0d right", v), r_dout,
            (VEC[v][7:6] == OP_RD) ? {9{VEC[v][0]}} : 9'h000);
    end

    // R10: error pulses for one cycle after an illegal access, per port
    @(negedge clk); drive_l(OP_BAD, 3'd1, 1'b0); drive_r(OP_IDLE, 3'd0, 1'b0);
    @(negedge clk); drive_l(OP_IDLE, 3'd0, 1'b0); #1;
    check("R10 left err raised", {8'd0, l_err}, 9'h001);
    check("R10 right err quiet", {8'd0, r_err}, 9'h000);
    @(negedge clk); #1;
    check("R10 left err one cycle", {8'd0, l_err}, 9'h000);
    @(negedge clk); drive_l(OP_RD, 3'd1, 1'b0); #1;
    check("R10 illegal claim ignored", l_dout, 9'h1FF);

    // R2: memory-side write (ce=1, sel=0) does not touch tokens
    @(negedge clk); drive_l(OP_IDLE, 3'd1, 1'b0); l_ce = 1'b1; l_we = 1'b1;
    @(negedge clk); drive_l(OP_RD, 3'd1, 1'b0); drive_r(OP_WR, 3'd1, 1'b0); #1;
    check("R2 memory write ignored", l_dout, 9'h1FF);
    // R2: read with oe low drives zero; right now holds token 1
    @(negedge clk); drive_r(OP_RD, 3'd1, 1'b0); r_oe = 1'b0; #1;
    check("R2 oe low gives zero", r_dout, 9'h000);
    check("R6 left sees right's token", l_dout, 9'h1FF);

    @(negedge clk); drive_l(OP_IDLE, 3'd0, 1'b0); drive_r(OP_IDLE, 3'd0, 1'b0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule